// File: doc/BRIEF.md
# Shader Program and Swizzle Upload Port

This block takes register writes that load words into four upload memories belonging to two shader units: a program memory and a swizzle-pattern memory in the vertex unit, and the same pair in the geometry unit. Each memory has its own offset register. A write to a memory's data port stores the word at the current offset and then moves the offset up by one. Software can therefore stream a whole program through one port after setting the start offset once.

A data write whose offset has reached the memory depth stores nothing, leaves the offset where it is, and raises a one-cycle error pulse for that memory. When the geometry unit is not set up for exclusive configuration, every accepted vertex-unit word is also written into the matching geometry-unit memory at the same offset. The geometry unit's own offset register is not changed by this mirroring. Writes aimed at the geometry unit never reach the vertex unit.

The block presents registered write ports (enable and address per memory, plus one shared data bus) one cycle after the accepted data write. The memories themselves sit outside the block.

Top module: `prog_upload_port`

## Requirements
- R1: After reset every offset register is 0 and all write enables and error bits are low, so the first data write to any memory targets address 0.
- R2: An accepted data write appears on that memory's write port (enable high, address equal to the offset, `wdata` equal to the written word) in the cycle after the write is presented.
- R3: Each accepted data write increments that memory's offset by one, so back-to-back writes land on consecutive addresses.
- R4: `dat_addr[4:3]` picks the memory (0 vertex program, 1 vertex swizzle, 2 geometry program, 3 geometry swizzle), and `dat_addr[2:0]` is ignored, so all eight addresses of a group act as one data port.
- R5: Depths are 512 (vertex program), 4096 (geometry program) and 128 (each swizzle memory). A data write with the offset at or above the depth writes nothing, keeps the offset, and pulses `err[m]` for one cycle, where m is the memory code from R4.
- R6: With `geo_excl` low when the write is presented, an accepted vertex program or swizzle write also writes the geometry memory of the same kind at the same address.
- R7: With `geo_excl` high, vertex-unit writes do not touch the geometry unit.
- R8: Data writes to geometry memories never assert a vertex write enable.
- R9: An offset write (`ofs_we`, `ofs_sel` coded as in R4) loads the offset directly. If a data write to the same memory is presented in the same cycle, the offset write wins and the data write is dropped with no store and no error. A data write to a different memory in that cycle proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| geo_excl | input | 1 | Geometry unit exclusively configured; disables mirroring |
| ofs_we | input | 1 | Offset register write strobe |
| ofs_sel | input | 2 | Memory whose offset is written |
| ofs_val | input | 13 | New offset value |
| dat_we | input | 1 | Data port write strobe |
| dat_addr | input | 5 | Data port address: memory select and alias bits |
| dat_val | input | 32 | Word to upload |
| wdata | output | 32 | Registered word for all memory write ports |
| vp_we | output | 1 | Vertex program memory write enable |
| vp_addr | output | 9 | Vertex program memory address |
| vs_we | output | 1 | Vertex swizzle memory write enable |
| vs_addr | output | 7 | Vertex swizzle memory address |
| gp_we | output | 1 | Geometry program memory write enable |
| gp_addr | output | 12 | Geometry program memory address |
| gs_we | output | 1 | Geometry swizzle memory write enable |
| gs_addr | output | 7 | Geometry swizzle memory address |
| err | output | 4 | One-cycle out-of-range pulse per memory |

## Verification
The checker watches, on every cycle, that at most one error bit fires and never alongside a store into that memory, that consecutive vertex program stores climb by one address, and that mirroring follows the exclusive bit: vertex stores are copied to the same geometry address only when it was clear, and geometry-targeted writes never raise a vertex enable. Only the bench scenarios can show the exact boundary at each depth, that a refused write really leaves the offset in place, that the eight alias addresses are equivalent, and which write wins when an offset load collides with a data write.

// File: rtl/prog_upload_port.sv
module prog_upload_port #(
  parameter int DW       = 32,
  parameter int VP_DEPTH = 512,
  parameter int GP_DEPTH = 4096,
  parameter int SW_DEPTH = 128,
  parameter int ALIASES  = 8,
  parameter int OFW      = 13,
  localparam int VPAW = $clog2(VP_DEPTH),
  localparam int GPAW = $clog2(GP_DEPTH),
  localparam int SWAW = $clog2(SW_DEPTH),
  localparam int AAW  = $clog2(ALIASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            geo_excl,
  input  logic            ofs_we,
  input  logic [1:0]      ofs_sel,
  input  logic [OFW-1:0]  ofs_val,
  input  logic            dat_we,
  input  logic [AAW+1:0]  dat_addr,
  input  logic [DW-1:0]   dat_val,
  output logic [DW-1:0]   wdata,
  output logic            vp_we,
  output logic [VPAW-1:0] vp_addr,
  output logic            vs_we,
  output logic [SWAW-1:0] vs_addr,
  output logic            gp_we,
  output logic [GPAW-1:0] gp_addr,
  output logic            gs_we,
  output logic [SWAW-1:0] gs_addr,
  output logic [3:0]      err
);

  logic [3:0][OFW-1:0] ofs;
  logic [3:0]          take;
  logic [3:0]          oob;
  logic [1:0]          dsel;

  assign dsel = dat_addr[AAW+1:AAW];

  for (genvar m = 0; m < 4; m++) begin : g_mem
    localparam int DEPTH = (m == 0) ? VP_DEPTH : (m == 2) ? GP_DEPTH : SW_DEPTH;
    logic           hit;
    logic           inr;
    logic [OFW-1:0] ofs_q;

    assign hit     = dat_we && dsel == 2'(m) && !(ofs_we && ofs_sel == 2'(m));
    assign inr     = ofs_q < OFW'(DEPTH);
    assign take[m] = hit && inr;
    assign oob[m]  = hit && !inr;
    assign ofs[m]  = ofs_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                         ofs_q <= '0;
      else if (ofs_we && ofs_sel == 2'(m)) ofs_q <= ofs_val;
      else if (take[m])                   ofs_q <= ofs_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata   <= '0;
      vp_we   <= 1'b0;
      vp_addr <= '0;
      vs_we   <= 1'b0;
      vs_addr <= '0;
      gp_we   <= 1'b0;
      gp_addr <= '0;
      gs_we   <= 1'b0;
      gs_addr <= '0;
      err     <= '0;
    end else begin
      if (dat_we) wdata <= dat_val;
      vp_we   <= take[0];
      vp_addr <= ofs[0][VPAW-1:0];
      vs_we   <= take[1];
      vs_addr <= ofs[1][SWAW-1:0];
      gp_we   <= take[2] || (take[0] && !geo_excl);
      gp_addr <= take[2] ? ofs[2][GPAW-1:0] : GPAW'(ofs[0][VPAW-1:0]);
      gs_we   <= take[3] || (take[1] && !geo_excl);
      gs_addr <= take[3] ? ofs[3][SWAW-1:0] : ofs[1][SWAW-1:0];
      err     <= oob;
    end
  end

endmodule

// File: rtl/prog_upload_chk.sv
module prog_upload_chk #(
  parameter int VPAW = 9,
  parameter int GPAW = 12,
  parameter int SWAW = 7,
  parameter int AAW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            geo_excl,
  input logic            dat_we,
  input logic [AAW+1:0]  dat_addr,
  input logic            vp_we,
  input logic [VPAW-1:0] vp_addr,
  input logic            vs_we,
  input logic [SWAW-1:0] vs_addr,
  input logic            gp_we,
  input logic [GPAW-1:0] gp_addr,
  input logic            gs_we,
  input logic [SWAW-1:0] gs_addr,
  input logic [3:0]      err
);

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err)); // R5

  AST_ERR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (err[0] |-> !vp_we) and (err[1] |-> !vs_we)); // R5

  AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
    vp_we && $past(vp_we) |-> vp_addr == $past(vp_addr) + 1'b1); // R3

  AST_MIRROR_ON: assert property (@(posedge clk) disable iff (!rst_n)
    vp_we && !$past(geo_excl) |-> gp_we && gp_addr == GPAW'(vp_addr)); // R6

  AST_MIRROR_SWZ: assert property (@(posedge clk) disable iff (!rst_n)
    vs_we && !$past(geo_excl) |-> gs_we && gs_addr == vs_addr); // R6

  AST_MIRROR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_we || vs_we) && $past(geo_excl) |-> !gp_we && !gs_we); // R7

  AST_GEO_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dat_we && dat_addr[AAW+1]) |-> !vp_we && !vs_we); // R8

endmodule

bind prog_upload_port prog_upload_chk #(
  .VPAW(VPAW), .GPAW(GPAW), .SWAW(SWAW), .AAW(AAW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .geo_excl(geo_excl),
  .dat_we(dat_we), .dat_addr(dat_addr),
  .vp_we(vp_we), .vp_addr(vp_addr), .vs_we(vs_we), .vs_addr(vs_addr),
  .gp_we(gp_we), .gp_addr(gp_addr), .gs_we(gs_we), .gs_addr(gs_addr),
  .err(err)
);

// File: tb/prog_upload_port_tb.sv
module prog_upload_port_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        geo_excl = 1'b0;
  logic        ofs_we = 1'b0;
  logic [1:0]  ofs_sel = '0;
  logic [12:0] ofs_val = '0;
  logic        dat_we = 1'b0;
  logic [4:0]  dat_addr = '0;
  logic [31:0] dat_val = '0;
  logic [31:0] wdata;
  logic        vp_we, vs_we, gp_we, gs_we;
  logic [8:0]  vp_addr;
  logic [6:0]  vs_addr, gs_addr;
  logic [11:0] gp_addr;
  logic [3:0]  err;

  always #(PERIOD/2) clk = ~clk;

  prog_upload_port u_dut (
    .clk(clk), .rst_n(rst_n), .geo_excl(geo_excl),
    .ofs_we(ofs_we), .ofs_sel(ofs_sel), .ofs_val(ofs_val),
    .dat_we(dat_we), .dat_addr(dat_addr), .dat_val(dat_val),
    .wdata(wdata),
    .vp_we(vp_we), .vp_addr(vp_addr), .vs_we(vs_we), .vs_addr(vs_addr),
    .gp_we(gp_we), .gp_addr(gp_addr), .gs_we(gs_we), .gs_addr(gs_addr),
    .err(err)
  );

  typedef struct {
    bit [3:0] we;
    bit [3:0] er;
    int       a [4];
    int       d;
    string    tag;
  } exp_t;

  exp_t q [$];
  int   checks = 0;
  int   errors = 0;
  int   ofs [4] = '{0, 0, 0, 0};
  int   dep [4] = '{512, 128, 4096, 128};

  task automatic step(input bit ow, input int os, input int ov,
                      input bit dw, input int da, input int dv,
                      input bit ex, input string tag);
    exp_t e;
    int   m;
    @(negedge clk);
    ofs_we = ow; ofs_sel = 2'(os); ofs_val = 13'(ov);
    dat_we = dw; dat_addr = 5'(da); dat_val = dv; geo_excl = ex;
    e.we = '0; e.er = '0; e.d = dv; e.tag = tag;
    for (int i = 0; i < 4; i++) e.a[i] = 0;
    m = da >> 3;
    if (dw && !(ow && os == m)) begin
      if (ofs[m] < dep[m]) begin
        e.we[m] = 1'b1; e.a[m] = ofs[m];
        if (m < 2 && !ex) begin e.we[m+2] = 1'b1; e.a[m+2] = ofs[m]; end
        ofs[m]++;
      end else e.er[m] = 1'b1;
    end
    if (ow) ofs[os] = ov;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, geo_excl, tag);
  endtask

  always begin
    exp_t e;
    bit [3:0] gw;
    int ga [4];
    bit bad;
    @(posedge clk); #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      gw = {gs_we, gp_we, vs_we, vp_we};
      ga[0] = int'(vp_addr); ga[1] = int'(vs_addr);
      ga[2] = int'(gp_addr); ga[3] = int'(gs_addr);
      bad = (gw != e.we) || (err != e.er) || (e.we != 0 && wdata != e.d);
      for (int i = 0; i < 4; i++) if (e.we[i] && ga[i] != e.a[i]) bad = 1'b1;
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s: got we=%b err=%b addr=%0d/%0d/%0d/%0d data=%h exp we=%b err=%b addr=%0d/%0d/%0d/%0d data=%h",
                 e.tag, gw, err, ga[0], ga[1], ga[2], ga[3], wdata,
                 e.we, e.er, e.a[0], e.a[1], e.a[2], e.a[3], e.d);
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({vp_we, vs_we, gp_we, gs_we} != 0 || err != 0) begin
      errors++;
      $display("FAIL R1 reset: got we=%b err=%b exp 0000/0000",
               {vp_we, vs_we, gp_we, gs_we}, err);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R6: first vertex program write goes to 0 and is mirrored
    step(0, 0, 0, 1, 0, 32'hA000_0000, 0, "R1 R2 R6 first write");
    // R4 R3: the other seven aliases act as one port
    for (int k = 1; k < 8; k++) step(0, 0, 0, 1, k, 32'hA000_0000 + k, 0, "R4 R3 alias stream");
    // R7: exclusive geometry config stops mirroring
    step(0, 0, 0, 1, 2, 32'hB000_0001, 1, "R7 no mirror");
    step(0, 0, 0, 1, 5, 32'hB000_0002, 1, "R7 no mirror");
    // R8: geometry program uses its own offset, no vertex write
    step(0, 0, 0, 1, 16, 32'hC000_0000, 0, "R8 geometry program");
    step(0, 0, 0, 1, 23, 32'hC000_0001, 0, "R8 geometry program");
    // R6 swizzle mirror then geometry swizzle
    for (int k = 8; k < 11; k++) step(0, 0, 0, 1, k, 32'hD000_0000 + k, 0, "R6 swizzle mirror");
    step(0, 0, 0, 1, 24, 32'hD100_0000, 0, "R8 geometry swizzle");
    // R5: vertex program boundary
    step(1, 0, 510, 0, 0, 0, 0, "R9 offset load");
    step(0, 0, 0, 1, 1, 32'hE000_0001, 1, "R5 below depth");
    step(0, 0, 0, 1, 2, 32'hE000_0002, 1, "R5 last word");
    step(0, 0, 0, 1, 3, 32'hE000_0003, 1, "R5 refused");
    step(0, 0, 0, 1, 4, 32'hE000_0004, 1, "R5 offset kept");
    // R5: geometry program boundary
    step(1, 2, 4095, 0, 0, 0, 0, "R9 offset load");
    step(0, 0, 0, 1, 17, 32'hE100_0000, 0, "R5 geometry last word");
    step(0, 0, 0, 1, 18, 32'hE100_0001, 0, "R5 geometry refused");
    // R5: swizzle boundaries
    step(1, 3, 127, 0, 0, 0, 0, "R9 offset load");
    step(0, 0, 0, 1, 25, 32'hE200_0000, 0, "R5 swizzle last word");
    step(0, 0, 0, 1, 26, 32'hE200_0001, 0, "R5 swizzle refused");
    step(1, 1, 128, 0, 0, 0, 0, "R9 offset load");
    step(0, 0, 0, 1, 9, 32'hE300_0000, 0, "R5 vertex swizzle refused no mirror");
    // R9: offset write wins over same-memory data write
    step(1, 0, 5, 1, 0, 32'hF000_0000, 0, "R9 collision dropped");
    step(0, 0, 0, 1, 6, 32'hF000_0001, 0, "R9 new offset used");
    // R9: offset write to another memory does not block data
    step(1, 2, 9, 1, 3, 32'hF000_0002, 0, "R9 other memory proceeds");
    step(0, 0, 0, 1, 20, 32'hF000_0003, 0, "R9 loaded geometry offset");
    // R5: recovery after refusal
    step(1, 1, 3, 0, 0, 0, 0, "R9 offset load");
    step(0, 0, 0, 1, 12, 32'hF000_0004, 1, "R5 recovery");
    idle("idle");
    idle("idle");
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule